// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block performs one iteration of a radix-2 non-restoring division each time it is given a command. It keeps three flag bits between commands: a quotient-sign bit (Q), a divisor-sign bit (M) and a result bit (T). Software or a sequencer sets the flags up for unsigned or signed operation, and then issues the step command once per quotient bit. Each step returns the new partial remainder and the new T, which is the next quotient bit.

A full quotient is collected outside the block. Before each step the caller rotates the current T into a quotient register. The bit that falls out of the top of that register is written back into T through a load command. Thirty-two step and rotate pairs, plus one last rotate, give a 32-bit quotient. For signed operands the caller applies the usual one's-complement pre- and post-adjustments around the loop. Commands take effect on the clock edge at which the strobe is high, and everything holds when no command is given.

Top module: `divstep_unit`

## Requirements
- R1: Opcode 2'b01 (unsigned setup) clears Q, M and T to 0 on the edge where it is strobed.
- R2: Opcode 2'b10 (signed setup) loads Q from bit W-1 of `rn_in`, M from bit W-1 of `rm_in`, and T with Q XOR M.
- R3: Opcode 2'b11 (step) forms the shifted remainder {rn_in[W-2:0], T} and sets the new Q to the old `rn_in[W-1]`. It subtracts `rm_in` when the old Q equals M, and adds `rm_in` otherwise. The sum is presented on `rn_out` one edge later.
- R4: For a step, the carry/borrow bit is 1 in two cases: when a subtraction gives a result unsigned-greater than the shifted value, or when an addition gives a result unsigned-less than it. The new Q is the shifted-out bit XOR M XOR that carry/borrow bit.
- R5: After a step, T is 1 exactly when the new Q equals M, and M is unchanged.
- R6: Opcode 2'b00 (flag load) copies `t_in` into T and leaves Q, M and `rn_out` unchanged.
- R7: While `cmd_valid` is low, Q, M, T and `rn_out` keep their values whatever the other inputs do. `rn_out` changes only on a step.
- R8: After reset, Q, M and T read 0 and `rn_out` reads 0.
- R9: Unsigned setup followed by 32 rotate-and-step pairs and a final rotate yields the unsigned quotient of any 32-bit dividend by any non-zero divisor.
- R10: Signed setup, used with the one's-complement adjustment of a negative dividend before the loop and a carry add after it, yields the two's-complement quotient truncated toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 00 flag load, 01 unsigned setup, 10 signed setup, 11 step |
| rn_in | input | W | Partial remainder (step) or dividend-side operand (signed setup) |
| rm_in | input | W | Divisor |
| t_in | input | 1 | Value written into T by the flag-load command |
| rn_out | output | W | Partial remainder produced by the last step |
| q_flag | output | 1 | Q flag |
| m_flag | output | 1 | M flag |
| t_flag | output | 1 | T flag |

## Verification
Four hand-picked single steps each land in one quadrant of the add/subtract and carry/no-carry space, which separates a wrong operation choice from a wrong carry polarity. Whole 32-step unsigned divisions run over random operands and over edge operands: a zero dividend, a divisor of one, the largest values, and a divisor larger than the dividend. A wrong bit anywhere in the recurrence shows up as a wrong quotient. Signed divisions cover all four sign combinations and the most negative dividend, which exercises the M-driven choice between add and subtract and the correction steps. Idle cycles with busy inputs, and flag loads, show that nothing else moves.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  typedef enum logic [1:0] {
    OP_LOADT = 2'b00,
    OP_CLRU  = 2'b01,
    OP_SETS  = 2'b10,
    OP_STEP  = 2'b11
  } divstep_op_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } divstep_flags_t;

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu
  import divstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   rn,
  input  logic [W-1:0]   rm,
  input  divstep_flags_t cur,
  output logic [W-1:0]   rn_nx,
  output logic           q_nx,
  output logic           t_nx
);
  localparam int MSB = W - 1;

  logic [W-1:0] shifted;
  logic         do_sub;
  logic         cy;

  always_comb begin
    shifted = {rn[MSB-1:0], cur.t};
    do_sub  = (cur.q == cur.m);
    if (do_sub) begin
      rn_nx = shifted - rm;
      cy    = (rn_nx > shifted);
    end else begin
      rn_nx = shifted + rm;
      cy    = (rn_nx < shifted);
    end
    q_nx = rn[MSB] ^ cur.m ^ cy;
    t_nx = (q_nx == cur.m);
  end

endmodule

// File: rtl/divstep_flagreg.sv
module divstep_flagreg
  import divstep_pkg::*;
(
  input  logic           clk,
  input  logic           arst_n,
  input  logic           cmd_valid,
  input  divstep_op_e    op,
  input  logic           dvd_msb,
  input  logic           dvs_msb,
  input  logic           t_load,
  input  logic           step_q,
  input  logic           step_t,
  output divstep_flags_t flags
);

  divstep_flags_t flags_nx;
  logic           flags_en;

  always_comb begin
    flags_en = cmd_valid;
    flags_nx = flags;
    unique case (op)
      OP_CLRU: flags_nx = '{q: 1'b0, m: 1'b0, t: 1'b0};
      OP_SETS: flags_nx = '{q: dvd_msb, m: dvs_msb, t: dvd_msb ^ dvs_msb};
      OP_STEP: flags_nx = '{q: step_q, m: flags.m, t: step_t};
      OP_LOADT: flags_nx = '{q: flags.q, m: flags.m, t: t_load};
      default: flags_nx = flags;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_nx;
    end
  end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] rn_in,
  input  logic [W-1:0] rm_in,
  input  logic         t_in,
  output logic [W-1:0] rn_out,
  output logic         q_flag,
  output logic         m_flag,
  output logic         t_flag
);
  localparam int MSB = W - 1;

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[SYNC_LEN-1];

  divstep_op_e    op;
  divstep_flags_t flags;
  logic [W-1:0]   alu_rn;
  logic           alu_q;
  logic           alu_t;
  logic [W-1:0]   rn_nx;
  logic           rn_en;

  assign op = divstep_op_e'(cmd_op);

  divstep_alu #(.W(W)) u_alu (
    .rn    (rn_in),
    .rm    (rm_in),
    .cur   (flags),
    .rn_nx (alu_rn),
    .q_nx  (alu_q),
    .t_nx  (alu_t)
  );

  divstep_flagreg u_flags (
    .clk       (clk),
    .arst_n    (core_rst_n),
    .cmd_valid (cmd_valid),
    .op        (op),
    .dvd_msb   (rn_in[MSB]),
    .dvs_msb   (rm_in[MSB]),
    .t_load    (t_in),
    .step_q    (alu_q),
    .step_t    (alu_t),
    .flags     (flags)
  );

  always_comb begin
    rn_en = cmd_valid && (op == OP_STEP);
    rn_nx = alu_rn;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rn_out <= '0;
    end else if (rn_en) begin
      rn_out <= rn_nx;
    end
  end

  assign q_flag = flags.q;
  assign m_flag = flags.m;
  assign t_flag = flags.t;

endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         core_rst_n,
  input logic         cmd_valid,
  input logic [1:0]   cmd_op,
  input logic [W-1:0] rn_in,
  input logic [W-1:0] rm_in,
  input logic         t_in,
  input logic [W-1:0] rn_out,
  input logic         q_flag,
  input logic         m_flag,
  input logic         t_flag
);

  // R1
  a_r1_unsigned_clear: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && cmd_op == 2'b01) |=> (!q_flag && !m_flag && !t_flag));

  // R2
  a_r2_signed_setup: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && cmd_op == 2'b10) |=>
      (q_flag == $past(rn_in[W-1]) && m_flag == $past(rm_in[W-1]) && t_flag == (q_flag ^ m_flag)));

  // R5
  a_r5_step_t_rule: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> (t_flag == (q_flag == m_flag) && $stable(m_flag)));

  // R6
  a_r6_load_t: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && cmd_op == 2'b00) |=>
      (t_flag == $past(t_in) && $stable(q_flag) && $stable(m_flag) && $stable(rn_out)));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cmd_valid |=> ($stable(q_flag) && $stable(m_flag) && $stable(t_flag) && $stable(rn_out)));

  // R3: the low bit of a subtract result follows T minus the divisor low bit
  a_r3_low_bit: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> (rn_out[0] == ($past(t_flag) ^ $past(rm_in[0]))));

endmodule

bind divstep_unit divstep_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .rn_in      (rn_in),
  .rm_in      (rm_in),
  .t_in       (t_in),
  .rn_out     (rn_out),
  .q_flag     (q_flag),
  .m_flag     (m_flag),
  .t_flag     (t_flag)
);

// File: tb/divstep_unit_test.sv
`timescale 1ns/1ps
module divstep_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [W-1:0] rn_in, rm_in;
  logic         t_in;
  logic [W-1:0] rn_out;
  logic         q_flag, m_flag, t_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  divstep_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rn_in(rn_in), .rm_in(rm_in), .t_in(t_in), .rn_out(rn_out),
    .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [W-1:0] rn, input logic [W-1:0] rm, input logic tb);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; rn_in = rn; rm_in = rm; t_in = tb;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic loop32(inout logic [W-1:0] r1, inout logic [W-1:0] r2, input logic [W-1:0] dvs);
    for (int i = 0; i < 32; i++) begin
      logic top;
      top = r2[W-1];
      r2  = {r2[W-2:0], t_flag};
      issue(2'b00, '0, '0, top);
      issue(2'b11, r1, dvs, 1'b0);
      r1 = rn_out;
    end
  endtask

  task automatic udiv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r1, r2;
    r1 = '0; r2 = a;
    issue(2'b01, '0, '0, 1'b0);
    loop32(r1, r2, b);
    r2 = {r2[W-2:0], t_flag};
    check(r2 == a / b, "R9 unsigned quotient", r2, a / b);
  endtask

  task automatic sdiv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r1, r2, exp;
    logic         sg, top;
    sg  = a[W-1];
    r1  = sg ? '1 : '0;
    r2  = a - {{(W-1){1'b0}}, sg};
    issue(2'b10, r1, b, 1'b0);
    loop32(r1, r2, b);
    top = r2[W-1];
    r2  = {r2[W-2:0], t_flag};
    r2  = r2 + {{(W-1){1'b0}}, top};
    exp = W'($signed(a) / $signed(b));
    check(r2 == exp, "R10 signed quotient", r2, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    cmd_valid = 0; cmd_op = 0; rn_in = 0; rm_in = 0; t_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check({q_flag, m_flag, t_flag} == 3'b000, "R8 flags", {q_flag, m_flag, t_flag}, 0);
    check(rn_out == 0, "R8 rn_out", rn_out, 0);

    // R2 signed setup with mixed signs
    issue(2'b10, 32'h8000_0000, 32'h0000_0001, 1'b0);
    check({q_flag, m_flag, t_flag} == 3'b101, "R2 setup", {q_flag, m_flag, t_flag}, 3'b101);
    issue(2'b10, 32'hF000_0000, 32'h8000_0000, 1'b0);
    check({q_flag, m_flag, t_flag} == 3'b110, "R2 setup both neg", {q_flag, m_flag, t_flag}, 3'b110);
    // R1 clear
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check({q_flag, m_flag, t_flag} == 3'b000, "R1 clear", {q_flag, m_flag, t_flag}, 0);

    // R6 flag load
    issue(2'b00, 32'h1234_5678, 32'h1, 1'b1);
    check({q_flag, m_flag, t_flag} == 3'b001, "R6 load T", {q_flag, m_flag, t_flag}, 3'b001);
    check(rn_out == 0, "R6 rn_out untouched", rn_out, 0);

    // R3/R4/R5 subtract, no borrow: Q=M=0 T=1
    issue(2'b11, 32'h8000_0001, 32'h0000_0001, 1'b0);
    check(rn_out == 32'h2, "R3 subtract result", rn_out, 32'h2);
    check({q_flag, t_flag} == 2'b10, "R4 R5 subtract flags", {q_flag, t_flag}, 2'b10);

    // R3/R4 subtract with borrow: Q=M=0, T=0, rn=1, rm=5 -> 2-5
    issue(2'b01, '0, '0, 1'b0);
    issue(2'b11, 32'h0000_0001, 32'h0000_0005, 1'b0);
    check(rn_out == 32'hFFFF_FFFD, "R3 subtract borrow result", rn_out, 32'hFFFF_FFFD);
    check({q_flag, t_flag} == 2'b10, "R4 borrow flags", {q_flag, t_flag}, 2'b10);

    // R3 add, no carry: Q=1 M=0 T=1
    issue(2'b10, 32'h8000_0000, 32'h0, 1'b0);
    issue(2'b11, 32'h0000_0005, 32'h0000_0003, 1'b0);
    check(rn_out == 32'hE, "R3 add result", rn_out, 32'hE);
    check({q_flag, m_flag, t_flag} == 3'b001, "R4 R5 add flags", {q_flag, m_flag, t_flag}, 3'b001);

    // R4 add with carry: Q=1 M=0 T=1, rn=0x80000000 -> shifted 1, +0xFFFFFFFF -> 0, carry
    issue(2'b10, 32'h8000_0000, 32'h0, 1'b0);
    issue(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    check(rn_out == 32'h0, "R3 add carry result", rn_out, 0);
    check({q_flag, t_flag} == 2'b01, "R4 carry flags", {q_flag, t_flag}, 2'b01);

    // R7 idle with busy inputs
    @(negedge clk);
    cmd_op = 2'b01; rn_in = 32'hDEAD_BEEF; rm_in = 32'h8000_0000; t_in = 1'b0;
    repeat (3) @(negedge clk);
    check({q_flag, m_flag, t_flag} == 3'b001, "R7 idle flags", {q_flag, m_flag, t_flag}, 3'b001);
    check(rn_out == 32'h0, "R7 idle rn_out", rn_out, 0);

    // R9 unsigned edge operands then random
    udiv(32'h0, 32'h7);
    udiv(32'hFFFF_FFFF, 32'h1);
    udiv(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    udiv(32'h0000_0005, 32'h8000_0000);
    udiv(32'h8000_0000, 32'h0000_0003);
    for (int i = 0; i < 40; i++) begin
      a = $urandom; b = $urandom >> ($urandom % 32);
      if (b == 0) b = 1;
      udiv(a, b);
    end

    // R10 signed sign combinations and edges, then random
    sdiv(32'd100, 32'd7);
    sdiv(-32'sd100, 32'd7);
    sdiv(32'd100, -32'sd7);
    sdiv(-32'sd100, -32'sd7);
    sdiv(32'h8000_0000, 32'd2);
    sdiv(-32'sd7, 32'd2);
    for (int i = 0; i < 40; i++) begin
      a = $urandom; b = $urandom >>> ($urandom % 32);
      if (b == 0) b = 3;
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) b = 5;
      sdiv(a, b);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule